// File: doc/BRIEF.md
# Maskable Interrupt Status Register

This block holds the pending-interrupt state of a small microcontroller. Single-cycle event pulses from the serial port (receive error, receive buffer full, transmit buffer empty), the time base tick, external interrupt line 1 and the timer overflow each set a sticky flag bit. Software reads the flags through a register port and acknowledges them by writing zeros. A write can never raise a flag.

A mask register sits at a second address. A read of the status address returns only the flags whose mask bit is set. The same masked view, reduced by OR, drives one interrupt request line toward the core. While the serial port is disabled, its receive error flag is held clear.

Top module: `intflag_status`

## Requirements
- R1: After reset every flag is 0, the mask register is 0 and `irqOut` is 0.
- R2: A 1 on `evtIn[i]` at a clock edge sets flag i, visible after that edge. The flag positions are: bit 6 serial receive error, bit 5 receive buffer full, bit 4 transmit buffer empty, bit 3 time base tick, bit 2 external interrupt 1, bit 0 timer overflow. `evtIn` uses the same positions.
- R3: Bits 7 and 1 are not implemented. They read as 0 at the status address even when their event input pulses and their mask bit is 1.
- R4: A flag stays set until it is cleared. Idle cycles do not change it.
- R5: A write to the status address (0xF) clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged. Such a write never sets a flag.
- R6: When an event pulse and a software clear reach the same bit in the same cycle, the flag ends up set.
- R7: While `uartEnable` is 0, flag 6 is cleared at each clock edge and stays 0, even when its event input pulses.
- R8: A read at the status address returns the flags ANDed bitwise with the mask register.
- R9: The mask register is written and read back in full, all 8 bits, at address 0xE.
- R10: `irqOut` is 1 exactly when the flags ANDed with the mask are not all zero.
- R11: A write to any other address changes neither flags nor mask. A read at any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| wrEn | input | 1 | Write strobe, sampled at the clock edge |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| evtIn | input | 8 | Event pulses, one bit per flag position |
| uartEnable | input | 1 | Serial port enable; low holds flag 6 clear |
| irqOut | output | 1 | Combined masked interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 4-bit address, status at 0xF and mask at 0xE. The 4-bit address leaves fourteen unused locations, so writes and reads that decode to nothing can be exercised next to the two real registers. Pulsing all eight event inputs while the mask is all ones brings the two unimplemented positions into view. The same-cycle event-and-clear case and the low serial enable are driven against flags that are already set.

// File: rtl/intflag_pkg.sv
package intflag_pkg;
  typedef struct packed {
    logic statusWr;
    logic maskWr;
    logic selStatus;
    logic selMask;
  } regStrobe_t;
endpackage

// File: rtl/intflag_ctrl.sv
module intflag_ctrl
  import intflag_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'hF,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 4'hE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output regStrobe_t        strb
);

  logic hitStatus;
  logic hitMask;

  always_comb begin
    hitStatus      = (addr == STATUS_ADDR);
    hitMask        = (addr == MASK_ADDR);
    strb.selStatus = hitStatus;
    strb.selMask   = hitMask;
    strb.statusWr  = wrEn && hitStatus;
    strb.maskWr    = wrEn && hitMask;
  end

  // R11: a single access never reaches both registers
  a_r11_write_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.statusWr, strb.maskWr}));
  a_r11_select_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selStatus, strb.selMask}));

endmodule

// File: rtl/intflag_datapath.sv
module intflag_datapath
  import intflag_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] IMPL_MASK = 8'b0111_1101,
  parameter int unsigned ERR_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] evtIn,
  input  logic              uartEnable,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  localparam logic [DATA_W-1:0] ERR_ONEHOT = DATA_W'(1) << ERR_BIT;

  logic [DATA_W-1:0] flagQ;
  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] maskedView;
  logic [DATA_W-1:0] settable;

  for (genvar i = 0; i < DATA_W; i++) begin : g_flag
    if (IMPL_MASK[i]) begin : g_impl
      localparam bit IS_ERR = (i == ERR_BIT);
      always_ff @(posedge clk) begin
        if (!rstN)                    flagQ[i] <= 1'b0;
        else if (IS_ERR && !uartEnable) flagQ[i] <= 1'b0;
        else if (evtIn[i])            flagQ[i] <= 1'b1;
        else if (strb.statusWr && !wrData[i]) flagQ[i] <= 1'b0;
      end
    end else begin : g_tied
      assign flagQ[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            maskQ <= '0;
    else if (strb.maskWr) maskQ <= wrData;
  end

  always_comb begin
    maskedView = flagQ & maskQ;
    irqOut     = |maskedView;
    if (strb.selStatus)    rdData = maskedView;
    else if (strb.selMask) rdData = maskQ;
    else                   rdData = '0;
    settable = uartEnable ? IMPL_MASK : (IMPL_MASK & ~ERR_ONEHOT);
  end

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) || 1'b1 |=> ((($past(evtIn) & $past(settable)) & ~flagQ) == '0));
  a_r3_unused_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.selStatus |-> ((rdData & ~IMPL_MASK) == '0));
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.statusWr && uartEnable) |=> (($past(flagQ) & ~flagQ) == '0));
  a_r5_no_sw_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.statusWr |=> ((flagQ & ~$past(flagQ) & ~$past(evtIn)) == '0));
  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    !uartEnable |=> !flagQ[ERR_BIT]);
  a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskQ != '0));

endmodule

// File: rtl/intflag_status.sv
module intflag_status
  import intflag_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'hF,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 4'hE,
  parameter logic [DATA_W-1:0] IMPL_MASK = 8'b0111_1101,
  parameter int unsigned ERR_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] evtIn,
  input  logic              uartEnable,
  output logic              irqOut
);

  regStrobe_t strb;

  intflag_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .strb(strb)
  );

  intflag_datapath #(
    .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK), .ERR_BIT(ERR_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .evtIn(evtIn),
    .uartEnable(uartEnable), .rdData(rdData), .irqOut(irqOut)
  );

endmodule

// File: tb/intflag_status_bench.sv
module intflag_status_bench;
  localparam logic [3:0] ST = 4'hF;
  localparam logic [3:0] MK = 4'hE;
  localparam logic [7:0] IMPL = 8'b0111_1101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] addr = '0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] evtIn = '0;
  logic uartEnable = 1'b1;
  logic irqOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [7:0] mFlags = '0;
  logic [7:0] mMask = '0;

  logic [7:0] expData[$];
  logic expIrq[$];
  string expTag[$];

  always #5 clk = ~clk;

  intflag_status u_intflag_status (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .evtIn(evtIn), .uartEnable(uartEnable), .irqOut(irqOut)
  );

  // monitor: pop expected items and compare at the falling edge
  always @(negedge clk) begin
    if (expData.size() > 0) begin
      logic [7:0] d;
      logic q;
      string t;
      d = expData.pop_front();
      q = expIrq.pop_front();
      t = expTag.pop_front();
      compared++;
      if (rdData !== d || irqOut !== q) begin
        mismatched++;
        $display("FAIL %s: rdData=%h irq=%b expected rdData=%h irq=%b", t, rdData, irqOut, d, q);
      end
    end
  end

  task automatic tick(input logic [7:0] evt, input logic we, input logic [3:0] a,
                      input logic [7:0] d, input logic en);
    logic [7:0] clr;
    @(posedge clk); #1;
    evtIn = evt; wrEn = we; addr = a; wrData = d; uartEnable = en;
    @(posedge clk); #1;
    evtIn = '0; wrEn = 1'b0;
    clr = (we && a == ST) ? ~d : 8'h00;
    mFlags = ((mFlags & ~clr) | evt) & IMPL;
    if (!en) mFlags[6] = 1'b0;
    if (we && a == MK) mMask = d;
  endtask

  task automatic check(input logic [3:0] a, input string tag);
    logic [7:0] e;
    addr = a;
    e = (a == ST) ? (mFlags & mMask) : (a == MK) ? mMask : 8'h00;
    expData.push_back(e);
    expIrq.push_back(|(mFlags & mMask));
    expTag.push_back(tag);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    check(ST, "R1 status after reset");
    check(MK, "R1 mask after reset");
    tick(8'h00, 1'b1, MK, 8'hFF, 1'b1);
    check(MK, "R9 mask all ones");
    tick(8'h01, 1'b0, ST, 8'h00, 1'b1);
    check(ST, "R2 timer overflow sets bit 0");
    tick(8'hFF, 1'b0, ST, 8'h00, 1'b1);
    check(ST, "R3 all events, bits 7 and 1 stay 0");
    tick(8'h00, 1'b0, ST, 8'h00, 1'b1);
    tick(8'h00, 1'b0, ST, 8'h00, 1'b1);
    check(ST, "R4 flags sticky over idle cycles");
    tick(8'h00, 1'b1, ST, 8'hF7, 1'b1);
    check(ST, "R5 zero bit clears bit 3 only");
    tick(8'h00, 1'b1, ST, 8'h00, 1'b1);
    check(ST, "R5 write all zeros clears all");
    tick(8'h00, 1'b1, ST, 8'hFF, 1'b1);
    check(ST, "R5 write of ones never sets");
    tick(8'h20, 1'b1, ST, 8'h00, 1'b1);
    check(ST, "R6 event beats same-cycle clear");
    tick(8'h00, 1'b1, MK, 8'h00, 1'b1);
    check(ST, "R8 R10 mask zero hides pending flag");
    tick(8'h00, 1'b1, MK, 8'h20, 1'b1);
    check(ST, "R8 R10 mask bit 5 shows flag");
    tick(8'h00, 1'b1, MK, 8'h82, 1'b1);
    check(MK, "R9 mask keeps unimplemented bits");
    check(ST, "R3 R8 unimplemented bits masked read 0");
    tick(8'h00, 1'b1, MK, 8'h40, 1'b1);
    tick(8'h40, 1'b0, ST, 8'h00, 1'b1);
    check(ST, "R2 receive error sets bit 6");
    tick(8'h00, 1'b0, ST, 8'h00, 1'b0);
    check(ST, "R7 enable low clears bit 6");
    tick(8'h40, 1'b0, ST, 8'h00, 1'b0);
    check(ST, "R7 event ignored while disabled");
    tick(8'h40, 1'b0, ST, 8'h00, 1'b1);
    check(ST, "R7 event sets bit 6 once re-enabled");
    tick(8'h00, 1'b1, 4'h3, 8'h00, 1'b1);
    check(4'h3, "R11 other address reads 0");
    check(ST, "R11 other address write leaves flags");
    check(MK, "R11 other address write leaves mask");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule